// File: doc/BRIEF.md
# External Bus Address Wait Inserter

This block sequences bus cycles on an external memory interface that has two chip-select spaces. Each space can have two optional wait states. The first is an address-setup wait placed directly before the address-strobe state T1. The second is an address-hold wait placed directly after T1. Both give an external address latch more margin. A 16-bit configuration register selects which of these waits are in force for each space. Its reset value turns all of them on.

A requester presents an address together with a valid flag. The block decodes the address into chip-select space 0, chip-select space 1, or neither. It then runs the matching sequence: optional setup wait, T1, optional hold wait, and a data state T2. The external WAIT input can stretch T2 but has no effect in either inserted wait. An address outside both spaces completes internally in one cycle, with no strobes. While a cycle is running the block drops its ready flag, so the next request waits until the sequencer is idle again.

Top module: `ext_bus_wait_seq`

## Requirements
- R1: After reset the configuration register reads 0xFFFF, so every setup and hold wait is enabled.
- R2: Register bit 0 enables the setup wait for space 0, bit 1 the hold wait for space 0, bit 2 the setup wait for space 1, and bit 3 the hold wait for space 1 (1 = inserted). Bits 15:4 always read 1, and writes to them are ignored.
- R3: With the setup-wait bit of the addressed space set, exactly one setup cycle comes before T1, so the strobe appears in cycle 1 after acceptance instead of cycle 0.
- R4: With the hold-wait bit of the addressed space set, exactly one hold cycle comes between T1 and T2.
- R5: The setup and hold selections of one space have no effect on accesses to the other space.
- R6: WAIT held high during the setup or hold wait does not lengthen either of them.
- R7: T2 lasts one cycle plus one extra cycle for each cycle in which WAIT is high at the end of T2. `cyc_done` pulses in the final T2 cycle.
- R8: The addressed space's chip select (cs_act bit n for space n) is high from the first state of the cycle through the last T2 cycle. The address strobe is high for exactly one cycle (T1). bus_addr holds the request address during the strobe.
- R9: Addresses whose bits 15:12 equal 1 target space 0, addresses whose bits 15:12 equal 2 target space 1, and all other addresses complete in the first cycle after acceptance with no chip select, no strobe and no effect from WAIT.
- R10: req_ready is high only while the sequencer is idle. It is low in the cycle after acceptance and high again in the cycle after cyc_done.
- R11: Out of reset the sequencer is idle: req_ready high, no chip select, no strobe, no cyc_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 16 | Write data for the configuration register |
| reg_rdata | output | 16 | Configuration register read value |
| req_valid | input | 1 | Access request |
| req_addr | input | 16 | Access address |
| req_ready | output | 1 | Sequencer idle; a valid request is taken on this edge |
| wait_in | input | 1 | External wait request, active high |
| cs_act | output | 2 | Chip select per space, active high |
| addr_strobe | output | 1 | Address latch enable, high during T1 |
| bus_addr | output | 16 | Latched address of the running cycle |
| cyc_done | output | 1 | Pulses in the last cycle of each access |

## Verification
The hardest case to reach is WAIT being asserted while the sequencer sits in a setup or hold wait. A correct design gives no sign of it at the ports; only a wrong design shows a longer cycle. The bench therefore holds WAIT high continuously from acceptance until a chosen number of T2 cycles have passed. It computes that point from the register bits of the addressed space, so every inserted wait is spent with WAIT high. Each vector then compares the exact chip-select length, strobe position and completion cycle against the length implied by the two wait bits and the wanted T2 stretch. Vectors give the two spaces opposite settings to show that each space uses only its own bits.

// File: rtl/ebw_pkg.sv
// Shared definitions for the external bus address wait inserter.
// Assumes exactly two chip-select spaces; the register layout relies on it.
package ebw_pkg;
    localparam int NUM_CS = 2;
    localparam int REG_W  = 16;
    localparam int CFG_W  = 2 * NUM_CS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_T1,
        ST_HOLD,
        ST_T2,
        ST_INT
    } ebw_state_e;
endpackage

// File: rtl/ebw_cfg_reg.sv
// Wait-insertion configuration register.
// Holds the per-space setup/hold enables in the low CFG_W bits; the upper
// bits are constant ones. Assumes whole-register (16-bit) writes.
module ebw_cfg_reg
    import ebw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [CFG_W-1:0] cfg
);
    localparam int HI_W = REG_W - CFG_W;

    logic [CFG_W-1:0] cfg_q;
    logic             unused_hi;

    // Store the enable bits; reset turns every wait on.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '1;
        else if (we)
            cfg_q <= wdata[CFG_W-1:0];
    end

    // Upper write bits have no storage behind them.
    assign unused_hi = ^wdata[REG_W-1:CFG_W];

    // Read value: constant ones above the enable field.
    always_comb begin
        rdata = {{HI_W{1'b1}}, cfg_q};
        cfg   = cfg_q;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0])));
endmodule

// File: rtl/ebw_decode.sv
// Chip-select space decoder.
// Compares the page field of an address with each space's page number.
// Assumes the page numbers differ, so at most one hit bit is set.
module ebw_decode
    import ebw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12,
    parameter int CS0_PAGE = 1,
    parameter int CS1_PAGE = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] hit
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;
    localparam logic [PAGE_W-1:0] PAGES [NUM_CS] = '{
        PAGE_W'(CS0_PAGE), PAGE_W'(CS1_PAGE)
    };

    logic [PAGE_LSB-1:0] unused_lo;

    // The offset inside a page does not take part in the decode.
    assign unused_lo = addr[PAGE_LSB-1:0];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_space
        // One comparator per space.
        always_comb hit[g] = (addr[ADDR_W-1:PAGE_LSB] == PAGES[g]);
    end
endmodule

// File: rtl/ebw_seq.sv
// Bus-cycle sequencer.
// Steps IDLE -> [SETUP] -> T1 -> [HOLD] -> T2 (stretched by WAIT) -> IDLE
// for decoded spaces, and IDLE -> INT -> IDLE for everything else.
// The wait choices are taken from the configuration at acceptance.
// WAIT is sampled only in T2.
module ebw_seq
    import ebw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NUM_CS-1:0] req_hit,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              wait_in,
    output logic              req_ready,
    output logic [NUM_CS-1:0] cs_act,
    output logic              addr_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cyc_done
);
    ebw_state_e        state, state_nx;
    logic [NUM_CS-1:0] sel_q;
    logic [NUM_CS-1:0] asw_bits, ahw_bits;
    logic              ahw_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept, asw_sel, ahw_sel, in_ext;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_bits
        // Split the register into per-space setup and hold enables.
        always_comb begin
            asw_bits[g] = cfg[2*g];
            ahw_bits[g] = cfg[2*g+1];
        end
    end

    // Acceptance and the wait choice of the addressed space.
    always_comb begin
        accept  = req_valid && (state == ST_IDLE);
        asw_sel = |(req_hit & asw_bits);
        ahw_sel = |(req_hit & ahw_bits);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (|req_hit) ? (asw_sel ? ST_SETUP : ST_T1) : ST_INT;
            ST_SETUP: state_nx = ST_T1;
            ST_T1:    state_nx = ahw_q ? ST_HOLD : ST_T2;
            ST_HOLD:  state_nx = ST_T2;
            ST_T2:    state_nx = wait_in ? ST_T2 : ST_IDLE;
            ST_INT:   state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Latch the target space, the hold choice and the address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ahw_q  <= 1'b0;
            addr_q <= '0;
        end else if (accept) begin
            sel_q  <= req_hit;
            ahw_q  <= ahw_sel;
            addr_q <= req_addr;
        end
    end

    // Output decode from the current state.
    always_comb begin
        in_ext      = state inside {ST_SETUP, ST_T1, ST_HOLD, ST_T2};
        req_ready   = (state == ST_IDLE);
        cs_act      = in_ext ? sel_q : '0;
        addr_strobe = (state == ST_T1);
        bus_addr    = addr_q;
        cyc_done    = ((state == ST_T2) && !wait_in) || (state == ST_INT);
    end

    assert_setup_ignores_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |=> (state == ST_T1));
    assert_hold_follows_t1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ($past(state) == ST_T1));
    assert_hold_ignores_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (state == ST_T2));
    assert_wait_stretches_t2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_T2) && wait_in) |=> (state == ST_T2));
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);
    assert_strobe_one_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> ($countones(cs_act) == 1));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((cs_act == '0) && !addr_strobe));
endmodule

// File: rtl/ext_bus_wait_seq.sv
// External bus address wait inserter, top level.
// Connects the configuration register, the space decoder and the cycle
// sequencer. Assumes a single clock and a synchronous active-low reset.
module ext_bus_wait_seq
    import ebw_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 12,
    parameter int CS0_PAGE = 1,
    parameter int CS1_PAGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              wait_in,
    output logic [1:0]        cs_act,
    output logic              addr_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cyc_done
);
    logic [CFG_W-1:0]  cfg;
    logic [NUM_CS-1:0] hit;

    ebw_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    ebw_decode #(
        .ADDR_W   (ADDR_W),
        .PAGE_LSB (PAGE_LSB),
        .CS0_PAGE (CS0_PAGE),
        .CS1_PAGE (CS1_PAGE)
    ) u_dec (
        .addr (req_addr),
        .hit  (hit)
    );

    ebw_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_hit     (hit),
        .cfg         (cfg),
        .wait_in     (wait_in),
        .req_ready   (req_ready),
        .cs_act      (cs_act),
        .addr_strobe (addr_strobe),
        .bus_addr    (bus_addr),
        .cyc_done    (cyc_done)
    );
endmodule

// File: tb/ext_bus_wait_seq_test.sv
// Self-checking bench: a vector table of (config, address, T2 stretch)
// walked by one loop, then directed register and reset cases.
module ext_bus_wait_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {cfg[3:0], addr[15:0], stretch[7:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'hF, 16'h1000, 8'd0},
        {4'h0, 16'h1234, 8'd0},
        {4'h1, 16'h1000, 8'd2},
        {4'h2, 16'h1FFF, 8'd1},
        {4'h4, 16'h2000, 8'd0},
        {4'h8, 16'h2ABC, 8'd3},
        {4'h3, 16'h2000, 8'd1},
        {4'hC, 16'h1000, 8'd0},
        {4'hF, 16'h0000, 8'd2},
        {4'hF, 16'h3000, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        wait_in = 1'b0;
    logic [1:0]  cs_act;
    logic        addr_strobe;
    logic [15:0] bus_addr;
    logic        cyc_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ext_bus_wait_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .wait_in(wait_in), .cs_act(cs_act),
        .addr_strobe(addr_strobe), .bus_addr(bus_addr), .cyc_done(cyc_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // One access; wait_in is high from acceptance through the wanted T2 stretch.
    task automatic run_access(input logic [15:0] a, input int w, input int s, input int h,
                              output int cs_cnt, output int ale_idx, output int ale_cnt,
                              output int done_idx, output int mask, output int rdy0,
                              output int addr_ale, output int rdy_after);
        bit fin = 0;
        cs_cnt = 0; ale_idx = -1; ale_cnt = 0; done_idx = -1; mask = 0;
        rdy0 = -1; addr_ale = -1; rdy_after = -1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        wait_in = 1'b0;
        @(posedge clk);
        for (int idx = 0; idx < 60 && !fin; idx++) begin
            @(negedge clk);
            req_valid = 1'b0;
            wait_in = (idx < s + 1 + h + w);
            #1;
            if (idx == 0) rdy0 = req_ready;
            if (cs_act != 2'b00) cs_cnt++;
            mask = mask | int'(cs_act);
            if (addr_strobe) begin
                ale_cnt++;
                ale_idx = idx;
                addr_ale = int'(bus_addr);
            end
            if (cyc_done) begin
                done_idx = idx;
                fin = 1;
            end
        end
        @(negedge clk);
        wait_in = 1'b0;
        #1;
        rdy_after = req_ready;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset read", int'(reg_rdata), 16'hFFFF);
        chk("R11 reset ready", int'(req_ready), 1);
        chk("R11 reset cs", int'(cs_act), 0);
        chk("R11 reset strobe", int'(addr_strobe), 0);
        chk("R11 reset done", int'(cyc_done), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  cfg;
            logic [15:0] a;
            int w, sp, s, h;
            int cs_cnt, ale_idx, ale_cnt, done_idx, mask, rdy0, addr_ale, rdy_after;
            cfg = VEC[v][27:24];
            a   = VEC[v][23:8];
            w   = int'(VEC[v][7:0]);
            sp  = (a[15:12] == 4'd1) ? 0 : (a[15:12] == 4'd2) ? 1 : -1;
            s   = (sp >= 0) ? int'(cfg[2*sp])   : 0;
            h   = (sp >= 0) ? int'(cfg[2*sp+1]) : 0;
            write_reg({12'h000, cfg});
            #1;
            chk("R2 readback", int'(reg_rdata), int'({12'hFFF, cfg}));
            run_access(a, w, s, h, cs_cnt, ale_idx, ale_cnt, done_idx, mask, rdy0,
                       addr_ale, rdy_after);
            chk("R10 busy after accept", rdy0, 0);
            chk("R10 ready after done", rdy_after, 1);
            if (sp >= 0) begin
                chk("R3 R5 strobe position", ale_idx, s);
                chk("R4 R6 R7 done position", done_idx, s + h + 1 + w);
                chk("R8 cs length", cs_cnt, s + h + 2 + w);
                chk("R8 strobe count", ale_cnt, 1);
                chk("R8 R9 cs space", mask, 1 << sp);
                chk("R8 bus address", addr_ale, int'(a));
            end else begin
                chk("R9 internal done", done_idx, 0);
                chk("R9 internal no cs", cs_cnt, 0);
                chk("R9 internal no strobe", ale_cnt, 0);
            end
        end

        // R2: upper bits ignored on write, low bits kept.
        write_reg(16'h0000);
        #1;
        chk("R2 zero write", int'(reg_rdata), 16'hFFF0);
        write_reg(16'h5A5A);
        #1;
        chk("R2 mixed write", int'(reg_rdata), 16'hFFFA);

        // R1: a second reset restores all enables.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset after write", int'(reg_rdata), 16'hFFFF);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule